// File: doc/BRIEF.md
# Event-Gated Digital Output Updater

This block drives a 32-bit digital output bus from a frame-written staging area. A frame parser hands it byte writes, addressed by a 2-bit byte index, while a network frame is in progress. It also reports the end of each frame and whether that frame was correct. Bytes written during a frame are staged. They become eligible for output only when the frame ends correct. A frame that ends corrupt throws its writes away.

The committed output register loads the eligible data only when the selected update event occurs. The event can be the end of any frame, the leading edge of either of two sync pulses, or the end of a correct frame that wrote at least one output byte.

Each commit is reported by a one-cycle valid pulse, even when the value does not change. Commits and pulses are held off while the watchdog status reports an expired watchdog. An external enable forces the pins low without disturbing the committed value.

Top module: `evt_out_updater`

## Requirements
- R1: After reset `dout` is 0 and `outValid` is 0.
- R2: A write with `wrAddr` = k loads `wrData` into bits [8k+7:8k] of the output word; index 0 controls bits [7:0]. Staged writes never reach `dout` before an update event.
- R3: With `mode` = 2'b00, every `frameEnd` pulse sampled while `wdOk` is high commits the eligible data. The commit is seen on `dout`, and `outValid` is high for one cycle, right after the clock edge that samples `frameEnd`.
- R4: A frame ending with `frameOk` = 0 does not change the eligible data. Its staged bytes are replaced by the last accepted value, so a following frame builds on that value.
- R5: With `mode` = 2'b01, a commit happens only at the first clock edge where `sync0` is seen high after being low. Holding `sync0` high does not repeat it. `sync1` and frame ends cause no commit.
- R6: With `mode` = 2'b10, commits follow the leading edge of `sync1` in the same way; `sync0` causes no commit.
- R7: With `mode` = 2'b11, a commit happens only at a `frameEnd` with `frameOk` = 1 whose frame had at least one byte write. A write in the same cycle as `frameEnd` counts. A frame with no write, or a corrupt frame, produces no pulse.
- R8: `outValid` pulses on every commit, including one that leaves `dout` unchanged.
- R9: While `wdOk` is low, no commit and no `outValid` pulse occur. Data accepted meanwhile stays eligible for a later event.
- R10: While `outEn` is low, `dout` is 0. The committed value is retained and keeps updating, and it reappears when `outEn` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe from the frame parser |
| wrAddr | input | 2 | Byte index of the write (0 = bits 7:0) |
| wrData | input | 8 | Byte value |
| frameEnd | input | 1 | One-cycle end-of-frame pulse |
| frameOk | input | 1 | Frame correctness, valid with frameEnd |
| sync0 | input | 1 | Sync pulse 0 (level; leading edge used) |
| sync1 | input | 1 | Sync pulse 1 (level; leading edge used) |
| wdOk | input | 1 | High when the watchdog is triggered or disabled |
| outEn | input | 1 | External output enable |
| mode | input | 2 | Update event select |
| dout | output | 32 | Digital output bus |
| outValid | output | 1 | One-cycle pulse per commit |

## Verification
Every result is registered once. A frame end or sync edge set up before clock edge N shows its effect on `outValid` and `dout` just after edge N. `outEn` acts on `dout` with no clock at all. The bench drives inputs on the falling edge and holds each strobe for exactly one cycle. It samples at the following falling edge, so the pulse and the data are read in the single cycle where they are due. It then samples again one cycle later to prove that a held sync level gives no second pulse.

// File: rtl/evt_out_pkg.sv
package evt_out_pkg;

  typedef enum logic [1:0] {
    MODE_EOF    = 2'b00,
    MODE_SYNC0  = 2'b01,
    MODE_SYNC1  = 2'b10,
    MODE_WDTRIG = 2'b11
  } updMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptFrame;  // frame ended correct: staged bytes become eligible
    logic dropFrame;    // frame ended corrupt: staged bytes restored
    logic commit;       // load eligible data into the output register
  } updStrobe_t;

endpackage

// File: rtl/evt_out_ctrl.sv
module evt_out_ctrl
  import evt_out_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       frameEnd,
  input  logic       frameOk,
  input  logic [1:0] syncIn,
  input  logic       wdOk,
  input  logic [1:0] mode,
  output updStrobe_t strb,
  output logic       outValid
);

  logic [1:0] syncPrev;
  logic [1:0] syncRise;
  logic       frameHit;
  logic       updEvent;
  logic       fire;
  updMode_e   modeSel;

  assign modeSel = updMode_e'(mode);

  // previous sync level follows the pins even during reset, so a level
  // already high at reset release is not taken as a leading edge
  always_ff @(posedge clk) begin
    syncPrev <= syncIn;
  end

  for (genvar s = 0; s < 2; s++) begin : g_edge
    assign syncRise[s] = syncIn[s] & ~syncPrev[s];
  end

  // remembers that the current frame wrote at least one output byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameHit <= 1'b0;
    end else if (frameEnd) begin
      frameHit <= 1'b0;
    end else if (wrEn) begin
      frameHit <= 1'b1;
    end
  end

  always_comb begin
    unique case (modeSel)
      MODE_EOF:    updEvent = frameEnd;
      MODE_SYNC0:  updEvent = syncRise[0];
      MODE_SYNC1:  updEvent = syncRise[1];
      MODE_WDTRIG: updEvent = frameEnd & frameOk & (frameHit | wrEn);
      default:     updEvent = 1'b0;
    endcase
  end

  assign fire = updEvent & wdOk;

  always_comb begin
    strb.acceptFrame = frameEnd & frameOk;
    strb.dropFrame   = frameEnd & ~frameOk;
    strb.commit      = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= fire;
    end
  end

endmodule

// File: rtl/evt_out_dpath.sv
module evt_out_dpath
  import evt_out_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DW = BYTES * 8,
  localparam int AW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  updStrobe_t    strb,
  input  logic          outEn,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] frameBuf;     // bytes staged by the frame in progress
  logic [DW-1:0] goodBuf;      // data of the last accepted frame
  logic [DW-1:0] committed;    // value behind the pins
  logic [DW-1:0] mergedFrame;  // staged bytes with this cycle's write applied
  logic [DW-1:0] goodNext;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign mergedFrame[b*8 +: 8] =
      (wrEn && (wrAddr == AW'(b))) ? wrData : frameBuf[b*8 +: 8];
  end

  assign goodNext = strb.acceptFrame ? mergedFrame : goodBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBuf  <= '0;
      goodBuf   <= '0;
      committed <= '0;
    end else begin
      frameBuf <= strb.dropFrame ? goodBuf : mergedFrame;
      goodBuf  <= goodNext;
      if (strb.commit) begin
        committed <= goodNext;
      end
    end
  end

  assign dout = outEn ? committed : '0;

endmodule

// File: rtl/evt_out_updater.sv
module evt_out_updater
  import evt_out_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DW = BYTES * 8,
  localparam int AW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic          frameEnd,
  input  logic          frameOk,
  input  logic          sync0,
  input  logic          sync1,
  input  logic          wdOk,
  input  logic          outEn,
  input  logic [1:0]    mode,
  output logic [DW-1:0] dout,
  output logic          outValid
);

  updStrobe_t strb;

  evt_out_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .frameEnd (frameEnd),
    .frameOk  (frameOk),
    .syncIn   ({sync1, sync0}),
    .wdOk     (wdOk),
    .mode     (mode),
    .strb     (strb),
    .outValid (outValid)
  );

  evt_out_dpath #(.BYTES(BYTES)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb),
    .outEn  (outEn),
    .dout   (dout)
  );

endmodule

// File: rtl/evt_out_updater_chk.sv
module evt_out_updater_chk #(
  parameter int BYTES = 4,
  localparam int DW = BYTES * 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameEnd,
  input logic          frameOk,
  input logic          sync0,
  input logic          sync1,
  input logic          wdOk,
  input logic          outEn,
  input logic [1:0]    mode,
  input logic [DW-1:0] dout,
  input logic          outValid
);

  // R9: an expired watchdog suppresses the pulse
  a_r9_wd_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !wdOk |=> !outValid);

  // R3: in frame-end mode a pulse needs a frame end one edge earlier
  a_r3_eof_only: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && !frameEnd) |=> !outValid);

  // R5: in sync0 mode only a sync0 leading edge yields a pulse
  a_r5_sync0_edge: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && !$rose(sync0)) |=> !outValid);

  // R6: in sync1 mode only a sync1 leading edge yields a pulse
  a_r6_sync1_edge: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && !$rose(sync1)) |=> !outValid);

  // R7: a corrupt frame never triggers in watchdog-trigger mode
  a_r7_bad_frame: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && frameEnd && !frameOk) |=> !outValid);

  // R10: the pins move only with a commit or an enable change
  a_r10_pins_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(outEn) && !outValid) |-> $stable(dout));

endmodule

bind evt_out_updater evt_out_updater_chk #(.BYTES(BYTES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .frameEnd (frameEnd),
  .frameOk  (frameOk),
  .sync0    (sync0),
  .sync1    (sync1),
  .wdOk     (wdOk),
  .outEn    (outEn),
  .mode     (mode),
  .dout     (dout),
  .outValid (outValid)
);

// File: tb/evt_out_updater_bench.sv
module evt_out_updater_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrAddr;
  logic [7:0]  wrData;
  logic        frameEnd;
  logic        frameOk;
  logic        sync0;
  logic        sync1;
  logic        wdOk;
  logic        outEn;
  logic [1:0]  mode;
  logic [31:0] dout;
  logic        outValid;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;
  logic seenPulse;

  always #10 clk = ~clk;  // 50 MHz

  evt_out_updater u_evt_out_updater (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameEnd(frameEnd), .frameOk(frameOk), .sync0(sync0), .sync1(sync1),
    .wdOk(wdOk), .outEn(outEn), .mode(mode), .dout(dout), .outValid(outValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic endFrame(input logic ok);
    @(negedge clk);
    frameEnd = 1'b1; frameOk = ok;
    @(negedge clk);
    frameEnd = 1'b0; frameOk = 1'b0;
    seenPulse = outValid;
  endtask

  // raise a sync line for two cycles; seenPulse is the first-cycle result
  task automatic syncPulse(input int which, input string req);
    @(negedge clk);
    if (which == 0) sync0 = 1'b1; else sync1 = 1'b1;
    @(negedge clk);
    seenPulse = outValid;
    @(negedge clk);
    check({req, " held level gives no second pulse"}, 32'(outValid), 32'd0);
    sync0 = 1'b0; sync1 = 1'b0;
  endtask

  task automatic testReset();
    check("R1 dout after reset", dout, 32'h0);
    check("R1 outValid after reset", 32'(outValid), 32'd0);
  endtask

  task automatic testEofMode();
    mode = 2'b00;
    writeByte(2'd0, 8'h11);
    writeByte(2'd1, 8'h22);
    writeByte(2'd2, 8'h33);
    writeByte(2'd3, 8'h44);
    check("R2 staged bytes not on pins", dout, 32'h0);
    endFrame(1'b1);
    check("R3 pulse at frame end", 32'(seenPulse), 32'd1);
    check("R2 byte lanes", dout, 32'h44332211);
    @(negedge clk);
    check("R3 pulse lasts one cycle", 32'(outValid), 32'd0);
  endtask

  task automatic testUnchanged();
    endFrame(1'b1);
    check("R8 pulse with unchanged data", 32'(seenPulse), 32'd1);
    check("R8 data unchanged", dout, 32'h44332211);
  endtask

  task automatic testBadFrame();
    writeByte(2'd1, 8'hAA);
    endFrame(1'b0);
    check("R4 corrupt frame leaves pins", dout, 32'h44332211);
    writeByte(2'd0, 8'h55);
    endFrame(1'b1);
    check("R4 discarded byte not revived", dout, 32'h44332255);
  endtask

  task automatic testSync0();
    mode = 2'b01;
    writeByte(2'd2, 8'h99);
    endFrame(1'b1);
    check("R5 frame end gives no pulse", 32'(seenPulse), 32'd0);
    check("R5 frame end gives no commit", dout, 32'h44332255);
    syncPulse(1, "R5");
    check("R5 sync1 ignored", 32'(seenPulse), 32'd0);
    syncPulse(0, "R5");
    check("R5 sync0 edge pulse", 32'(seenPulse), 32'd1);
    check("R5 sync0 edge commit", dout, 32'h44992255);
  endtask

  task automatic testSync1();
    mode = 2'b10;
    writeByte(2'd3, 8'h77);
    endFrame(1'b1);
    syncPulse(0, "R6");
    check("R6 sync0 ignored", 32'(seenPulse), 32'd0);
    check("R6 no commit on sync0", dout, 32'h44992255);
    syncPulse(1, "R6");
    check("R6 sync1 edge pulse", 32'(seenPulse), 32'd1);
    check("R6 sync1 edge commit", dout, 32'h77992255);
  endtask

  task automatic testWdTrig();
    mode = 2'b11;
    endFrame(1'b1);
    check("R7 frame without write no pulse", 32'(seenPulse), 32'd0);
    writeByte(2'd0, 8'h01);
    endFrame(1'b0);
    check("R7 corrupt frame no pulse", 32'(seenPulse), 32'd0);
    check("R7 corrupt frame no commit", dout, 32'h77992255);
    writeByte(2'd0, 8'h02);
    endFrame(1'b1);
    check("R7 writing frame pulse", 32'(seenPulse), 32'd1);
    check("R7 writing frame commit", dout, 32'h77992202);
    // write in the very cycle of the frame end
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h5A; frameEnd = 1'b1; frameOk = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; frameEnd = 1'b0; frameOk = 1'b0;
    check("R7 same-cycle write pulse", 32'(outValid), 32'd1);
    check("R7 same-cycle write commit", dout, 32'h775A2202);
  endtask

  task automatic testWatchdog();
    mode = 2'b00;
    wdOk = 1'b0;
    writeByte(2'd1, 8'hEE);
    endFrame(1'b1);
    check("R9 blocked pulse", 32'(seenPulse), 32'd0);
    check("R9 blocked commit", dout, 32'h775A2202);
    wdOk = 1'b1;
    endFrame(1'b1);
    check("R9 later pulse", 32'(seenPulse), 32'd1);
    check("R9 accepted data kept", dout, 32'h775AEE02);
  endtask

  task automatic testEnable();
    @(negedge clk);
    outEn = 1'b0;
    #1;
    check("R10 disabled pins low", dout, 32'h0);
    writeByte(2'd3, 8'h10);
    endFrame(1'b1);
    check("R10 pulse while disabled", 32'(seenPulse), 32'd1);
    check("R10 pins stay low", dout, 32'h0);
    @(negedge clk);
    outEn = 1'b1;
    #1;
    check("R10 committed value returns", dout, 32'h105AEE02);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    frameEnd = 1'b0; frameOk = 1'b0; sync0 = 1'b0; sync1 = 1'b0;
    wdOk = 1'b1; outEn = 1'b1; mode = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEofMode();
    testUnchanged();
    testBadFrame();
    testSync0();
    testSync1();
    testWdTrig();
    testWatchdog();
    testEnable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule